// File: doc/BRIEF.md
# Compare Timer with PWM Outputs and Prioritised Interrupt Vector

This block is a 16-bit timer for a microcontroller-style subsystem. A power-of-two prescaler slows the system clock before it reaches the counter. The counter can be stopped, can count up to a period, can run freely through the full 16-bit range, or can count down and reload. Three compare channels watch the counter. Each channel raises a match flag when the counter reaches that channel's compare value. A channel can also drive a pulse-width-modulated output that is cleared on its match and set again when the counter wraps. Channel 0 is special: its compare value is the period in up and down modes.

Software programs the block through a small word-addressed register bus. Channel 0 has its own interrupt line. The other channels and the overflow event share a second line. A vector register on that shared line returns a small even code for the most urgent enabled source that is pending. Reading the vector also clears the flag it reported, so a handler can service one source per read.

Top module: `tmr_ccp_top`

## Requirements
- R1: After a synchronous reset, every register reads 0, and `irq_ch0`, `irq_shared` and `pwm_out` are all 0.
- R2: Mode field 1 is up mode. On each prescaler tick the counter steps by +1. When it is at or above the channel 0 compare value, it instead goes to 0 and sets the overflow flag.
- R3: Mode field 2 is continuous mode. The counter steps by +1 and wraps from 0xFFFF to 0, and that wrap sets the overflow flag.
- R4: Mode field 3 is down mode. The counter steps by -1. At 0 it reloads the channel 0 compare value and sets the overflow flag.
- R5: A divider field value s makes the counter advance once every 2^s clock cycles while the timer runs. Mode field 0 stops the counter and holds its value.
- R6: A channel's match flag is set on the edge at which the counter takes that channel's compare value. The FLAGS register holds channel i's flag at bit i and the overflow flag at bit 3. Writing 1 to a FLAGS bit clears that flag.
- R7: `irq_ch0` is high while the channel 0 flag and channel 0's interrupt-enable bit are both set.
- R8: `irq_shared` is high while any enabled shared source is pending. A source is channel 1 or 2 with its enable bit set, or the overflow flag with the overflow-enable bit set. The vector register reads 2 for channel 1, 4 for channel 2, 6 for overflow, and 0 when none is pending. The lower code wins.
- R9: A bus read of the vector clears only the flag it reported. A vector read that returns 0 clears nothing.
- R10: If a match or a wrap sets a flag on the same edge that a vector read or a FLAGS write clears it, the flag ends up set.
- R11: With the PWM bit of a channel set, its output goes low on its match and high on a counter wrap or reload. The match takes priority when both happen on the same edge.
- R12: With the PWM bit clear, a channel's output follows that channel's output-value bit, one cycle after the register write.
- R13: Register map by word address: 0 CTRL (bits 1:0 mode, 4:2 divider, 5 overflow enable), 1 COUNT (a write loads the counter), 2 VECTOR, 3 FLAGS, 4+2i compare of channel i, 5+2i config of channel i (bit 0 interrupt enable, bit 1 PWM, bit 2 output value).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; qualifies the read side effect of the vector register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_ch0 | output | 1 | Channel 0 interrupt request |
| irq_shared | output | 1 | Shared interrupt request for channels 1..2 and overflow |
| pwm_out | output | 3 | Per-channel output pins |

## Verification
The delicate overlap is a flag that is cleared by software on the same edge that the hardware sets it again. The bench provokes this with a vector read that lands on the very edge where the counter reaches channel 1's compare value. It first leaves the channel 1 flag pending, then loads the counter with 2 and starts up mode just before the read. The read must still return code 2, and a second vector read afterwards must again return 2, because the set on that edge takes priority over the clear. The bench also checks that the interrupt-enable gating and a vector read that finds nothing pending leave the flags unchanged.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_STOP = 2'd0,
        MODE_UP   = 2'd1,
        MODE_CONT = 2'd2,
        MODE_DOWN = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        logic       ovf_ie;
        logic [2:0] div_sel;
        cnt_mode_e  mode;
    } tmr_ctrl_t;

    typedef struct packed {
        logic out_val;
        logic pwm_en;
        logic irq_en;
    } ch_ctrl_t;

    typedef struct packed {
        logic adv;
        logic wrap;
    } cnt_evt_t;

    localparam int CTRL_BITS = $bits(tmr_ctrl_t);
    localparam int CHC_BITS  = $bits(ch_ctrl_t);
    localparam int SEL_W     = 3;

    localparam int A_CTRL    = 0;
    localparam int A_COUNT   = 1;
    localparam int A_VEC     = 2;
    localparam int A_FLAGS   = 3;
    localparam int A_CH_BASE = 4;

    function automatic int cmp_addr(input int ch);
        return A_CH_BASE + 2 * ch;
    endfunction

    function automatic int cfg_addr(input int ch);
        return A_CH_BASE + 2 * ch + 1;
    endfunction

    // shared source j (0 = channel 1) reports an even code
    function automatic int vec_code(input int src_idx);
        return 2 * (src_idx + 1);
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [SW-1:0] sel,
    output logic          tick
);
    localparam int PW = (1 << SW) - 1;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] lim;

    assign lim  = PW'((32'd1 << sel) - 32'd1);
    assign tick = en && (pcnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !en)  pcnt <= '0;
        else if (tick)   pcnt <= '0;
        else             pcnt <= pcnt + 1'b1;
    end

    // R5: with a divider above 1, two ticks never come back to back
    assert_div_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && sel != '0) |=> (!tick || !$stable(sel)));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  cnt_mode_e     mode,
    input  logic [CW-1:0] period,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_val,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] nxt,
    output cnt_evt_t      evt
);
    logic wrap_c;
    logic adv_c;

    always_comb begin
        nxt    = cnt;
        wrap_c = 1'b0;
        unique case (mode)
            MODE_UP: begin
                if (cnt >= period) begin
                    nxt    = '0;
                    wrap_c = 1'b1;
                end else begin
                    nxt = cnt + 1'b1;
                end
            end
            MODE_CONT: begin
                nxt    = cnt + 1'b1;
                wrap_c = (cnt == '1);
            end
            MODE_DOWN: begin
                if (cnt == '0) begin
                    nxt    = period;
                    wrap_c = 1'b1;
                end else begin
                    nxt = cnt - 1'b1;
                end
            end
            default: begin
                nxt    = cnt;
                wrap_c = 1'b0;
            end
        endcase
    end

    assign adv_c    = tick && (mode != MODE_STOP) && !wr_en;
    assign evt.adv  = adv_c;
    assign evt.wrap = adv_c && wrap_c;

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (wr_en) cnt <= wr_val;
        else if (adv_c) cnt <= nxt;
    end

    assert_up_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (adv_c && mode == MODE_UP && cnt >= period) |=> (cnt == '0));

    assert_cont_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (adv_c && mode == MODE_CONT && cnt == '1) |=> (cnt == '0));

    assert_down_reload_R4: assert property (@(posedge clk) disable iff (rst)
        (adv_c && mode == MODE_DOWN && cnt == '0) |=> (cnt == $past(period)));

    assert_stop_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STOP && !wr_en) |=> $stable(cnt));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cmp,
    input  ch_ctrl_t      cfg,
    input  cnt_evt_t      evt,
    input  logic [CW-1:0] nxt,
    input  logic          clr,
    output logic          flag,
    output logic          pwm
);
    logic match;

    assign match = evt.adv && (nxt == cmp);

    // a set on the same edge as a clear wins (R10)
    always_ff @(posedge clk) begin
        if (rst)        flag <= 1'b0;
        else if (match) flag <= 1'b1;
        else if (clr)   flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)              pwm <= 1'b0;
        else if (!cfg.pwm_en) pwm <= cfg.out_val;
        else if (match)       pwm <= 1'b0;
        else if (evt.wrap)    pwm <= 1'b1;
    end

    assert_match_sets_flag_R10: assert property (@(posedge clk) disable iff (rst)
        match |=> flag);

    assert_pwm_reset_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg.pwm_en && match) |=> !pwm);

    assert_pwm_set_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg.pwm_en && evt.wrap && !match) |=> pwm);

endmodule

// File: rtl/tmr_irq_vector.sv
module tmr_irq_vector
    import tmr_pkg::*;
#(
    parameter int NSRC = 3,
    parameter int CW   = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src,
    output logic [NSRC-1:0] sel,
    output logic [CW-1:0]   code,
    output logic            irq
);
    always_comb begin
        sel  = '0;
        code = '0;
        irq  = 1'b0;
        for (int j = NSRC - 1; j >= 0; j--) begin
            if (src[j]) begin
                sel    = '0;
                sel[j] = 1'b1;
                code   = CW'(vec_code(j));
                irq    = 1'b1;
            end
        end
    end

    assert_one_reported_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($onehot(sel) && (sel & src) == sel && code != '0));

endmodule

// File: rtl/tmr_ccp_top.sv
module tmr_ccp_top
    import tmr_pkg::*;
#(
    parameter int CW     = 16,
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [CW-1:0]     bus_wdata,
    output logic [CW-1:0]     bus_rdata,
    output logic              irq_ch0,
    output logic              irq_shared,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int NSRC = NUM_CH;   // channels 1..NUM_CH-1 plus overflow

    tmr_ctrl_t         ctrl_q;
    ch_ctrl_t          cfg_q [NUM_CH];
    logic [CW-1:0]     cmp_q [NUM_CH];
    logic              ovf_q;
    logic [NUM_CH-1:0] flag;
    logic [NUM_CH-1:0] ch_clr;
    logic [CW-1:0]     cnt, nxt, vec_code_w;
    logic [NSRC-1:0]   src, vec_sel;
    cnt_evt_t          evt;
    logic              tick, cnt_wr, flags_wr, vec_rd, ovf_clr;

    assign cnt_wr   = bus_wr && (bus_addr == ADDR_W'(A_COUNT));
    assign flags_wr = bus_wr && (bus_addr == ADDR_W'(A_FLAGS));
    assign vec_rd   = bus_rd && (bus_addr == ADDR_W'(A_VEC));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            for (int i = 0; i < NUM_CH; i++) begin
                cfg_q[i] <= '0;
                cmp_q[i] <= '0;
            end
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(A_CTRL))
                ctrl_q <= tmr_ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == ADDR_W'(cmp_addr(i))) cmp_q[i] <= bus_wdata;
                if (bus_addr == ADDR_W'(cfg_addr(i)))
                    cfg_q[i] <= ch_ctrl_t'(bus_wdata[CHC_BITS-1:0]);
            end
        end
    end

    tmr_prescaler #(.SW(SEL_W)) u_pre (
        .clk (clk),
        .rst (rst),
        .en  (ctrl_q.mode != MODE_STOP),
        .sel (ctrl_q.div_sel),
        .tick(tick)
    );

    tmr_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .mode  (ctrl_q.mode),
        .period(cmp_q[0]),
        .tick  (tick),
        .wr_en (cnt_wr),
        .wr_val(bus_wdata),
        .cnt   (cnt),
        .nxt   (nxt),
        .evt   (evt)
    );

    assign ch_clr[0] = flags_wr && bus_wdata[0];

    generate
        for (genvar g = 1; g < NUM_CH; g++) begin : g_src
            assign src[g-1]  = flag[g] && cfg_q[g].irq_en;
            assign ch_clr[g] = (flags_wr && bus_wdata[g]) || (vec_rd && vec_sel[g-1]);
        end
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            tmr_channel #(.CW(CW)) u_ch (
                .clk (clk),
                .rst (rst),
                .cmp (cmp_q[g]),
                .cfg (cfg_q[g]),
                .evt (evt),
                .nxt (nxt),
                .clr (ch_clr[g]),
                .flag(flag[g]),
                .pwm (pwm_out[g])
            );
        end
    endgenerate

    assign src[NSRC-1] = ovf_q && ctrl_q.ovf_ie;
    assign ovf_clr     = (flags_wr && bus_wdata[NUM_CH]) || (vec_rd && vec_sel[NSRC-1]);

    always_ff @(posedge clk) begin
        if (rst)           ovf_q <= 1'b0;
        else if (evt.wrap) ovf_q <= 1'b1;
        else if (ovf_clr)  ovf_q <= 1'b0;
    end

    tmr_irq_vector #(.NSRC(NSRC), .CW(CW)) u_vec (
        .clk (clk),
        .rst (rst),
        .src (src),
        .sel (vec_sel),
        .code(vec_code_w),
        .irq (irq_shared)
    );

    assign irq_ch0 = flag[0] && cfg_q[0].irq_en;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CTRL))  bus_rdata = CW'(ctrl_q);
        if (bus_addr == ADDR_W'(A_COUNT)) bus_rdata = cnt;
        if (bus_addr == ADDR_W'(A_VEC))   bus_rdata = vec_code_w;
        if (bus_addr == ADDR_W'(A_FLAGS)) bus_rdata = CW'({ovf_q, flag});
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(cmp_addr(i))) bus_rdata = cmp_q[i];
            if (bus_addr == ADDR_W'(cfg_addr(i))) bus_rdata = CW'(cfg_q[i]);
        end
    end

    assert_wrap_sets_ovf_R2: assert property (@(posedge clk) disable iff (rst)
        evt.wrap |=> ovf_q);

    assert_vec_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && vec_sel[NSRC-1] && !evt.wrap) |=> !ovf_q);

    assert_irq0_tracks_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (flags_wr && bus_wdata[0] && !(evt.adv && nxt == cmp_q[0])) |=> !irq_ch0);

endmodule

// File: tb/tmr_ccp_top_tb.sv
module tmr_ccp_top_tb;
    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_ch0, irq_shared;
    logic [2:0]  pwm_out;
    logic        pin_chk = 1'b0;
    logic        done = 1'b0;

    int checks = 0;
    int failures = 0;

    logic [15:0] q_exp[$];
    string       q_req[$];

    always #5 clk = ~clk;

    tmr_ccp_top u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ch0(irq_ch0),
        .irq_shared(irq_shared), .pwm_out(pwm_out)
    );

    // monitor: pops one expected item per observation point
    always @(negedge clk) begin
        if ((bus_rd || pin_chk) && q_exp.size() > 0) begin
            logic [15:0] act;
            logic [15:0] exp;
            string       req;
            act = pin_chk ? {11'b0, irq_shared, irq_ch0, pwm_out} : bus_rdata;
            exp = q_exp.pop_front();
            req = q_req.pop_front();
            checks++;
            if (act !== exp) begin
                failures++;
                $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        bus_addr = a[3:0]; bus_wdata = d[15:0]; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [15:0] exp, input string req);
        @(posedge clk); #1;
        bus_addr = a[3:0]; bus_rd = 1'b1;
        q_exp.push_back(exp); q_req.push_back(req);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // expected pins = {irq_shared, irq_ch0, pwm_out[2:0]}
    task automatic pins_chk(input logic [4:0] exp, input string req);
        @(posedge clk); #1;
        pin_chk = 1'b1;
        q_exp.push_back({11'b0, exp}); q_req.push_back(req);
        @(posedge clk); #1;
        pin_chk = 1'b0;
    endtask

    function automatic int cv(input int mode, input int sel, input int ovfie);
        return (ovfie << 5) | (sel << 2) | mode;
    endfunction

    // runs the timer for exactly k clock cycles (k >= 2) then stops it
    task automatic run(input int mode, input int sel, input int ovfie, input int k);
        wr(A_CTRL, cv(mode, sel, ovfie));
        repeat (k - 2) @(posedge clk);
        wr(A_CTRL, cv(0, sel, ovfie));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd_chk(A_CTRL,  16'h0, "R1 ctrl");
        rd_chk(A_COUNT, 16'h0, "R1 count");
        rd_chk(A_VEC,   16'h0, "R1 vector");
        rd_chk(A_FLAGS, 16'h0, "R1 flags");
        rd_chk(cmp_addr(0), 16'h0, "R1 cmp0");
        pins_chk(5'b00000, "R1 pins");

        // setup: period 9, ch1 pwm at 4, ch2 at 7
        wr(cmp_addr(0), 9);
        wr(cmp_addr(1), 4);
        wr(cmp_addr(2), 7);
        wr(cfg_addr(0), 1);
        wr(cfg_addr(1), 3);
        wr(cfg_addr(2), 1);
        rd_chk(cmp_addr(2), 16'd7, "R13 cmp2 readback");

        run(1, 0, 1, 6);
        rd_chk(A_COUNT, 16'd6, "R2 up count");
        rd_chk(A_FLAGS, 16'h2, "R6 ch1 flag");
        pins_chk(5'b10000, "R8 shared irq, R11 pwm low");
        rd_chk(A_VEC, 16'd2, "R8 vector ch1");
        rd_chk(A_VEC, 16'd0, "R9 ch1 cleared by read");
        pins_chk(5'b00000, "R9 shared irq drops");

        run(1, 0, 1, 6);
        rd_chk(A_COUNT, 16'd2, "R2 wrap past period");
        rd_chk(A_FLAGS, 16'hD, "R6 flags ch0 ch2 ovf");
        pins_chk(5'b11010, "R7 irq_ch0, R11 pwm high after wrap");
        rd_chk(A_VEC, 16'd4, "R8 ch2 beats ovf");
        rd_chk(A_VEC, 16'd6, "R8 ovf next");
        rd_chk(A_VEC, 16'd0, "R8 none pending");
        wr(A_FLAGS, 16'hF);
        rd_chk(A_FLAGS, 16'h0, "R6 write one clears");
        pins_chk(5'b00010, "R7 irq_ch0 falls");

        run(1, 0, 1, 4);
        pins_chk(5'b10000, "R11 pwm low on match");
        wr(A_FLAGS, 16'hF);

        // R3 continuous
        wr(A_COUNT, 16'hFFFD);
        run(2, 0, 1, 4);
        rd_chk(A_COUNT, 16'd1, "R3 wrap at 0xFFFF");
        rd_chk(A_FLAGS, 16'h8, "R3 ovf flag");
        rd_chk(A_VEC, 16'd6, "R3 ovf vector");
        rd_chk(A_FLAGS, 16'h0, "R9 ovf cleared by read");

        // R4 down, overflow interrupt disabled
        wr(A_COUNT, 2);
        run(3, 0, 0, 4);
        rd_chk(A_COUNT, 16'd8, "R4 reload from period");
        rd_chk(A_FLAGS, 16'h9, "R4 ovf and ch0 flags");
        rd_chk(A_VEC, 16'd0, "R8 disabled ovf not reported");
        rd_chk(A_FLAGS, 16'h9, "R9 empty read clears nothing");
        pins_chk(5'b01010, "R8 shared irq gated off");
        wr(A_FLAGS, 16'hF);

        // R5 divider by 4
        wr(A_COUNT, 0);
        run(1, 2, 1, 12);
        rd_chk(A_COUNT, 16'd3, "R5 divide by four");
        rd_chk(A_COUNT, 16'd3, "R5 stop holds");

        // R10 read clear collides with a new match
        wr(A_FLAGS, 16'hF);
        wr(A_COUNT, 0);
        run(1, 0, 1, 5);
        wr(A_COUNT, 2);
        wr(A_CTRL, cv(1, 0, 1));
        rd_chk(A_VEC, 16'd2, "R10 vector at collision");
        wr(A_CTRL, cv(0, 0, 1));
        rd_chk(A_COUNT, 16'd6, "R10 count after collision");
        rd_chk(A_VEC, 16'd2, "R10 set wins over read clear");

        // R12 static output
        wr(A_FLAGS, 16'hF);
        wr(cfg_addr(2), 5);
        pins_chk(5'b00100, "R12 output value bit");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule